// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block takes two active-low interrupt request pins from outside the chip and turns them into clean, active-high interrupt requests for a processor core. Each pin is brought into the core clock domain through two flip-flops before any decision is made on it. A small configuration interface then selects, pin by pin, whether the request is treated as a level (a low pin means "request now", so several open-drain sources can share the line) or as a falling edge that is remembered until the core acknowledges it.

In edge mode a falling transition raises a pending flag that stays up after the pin returns high. It is cleared by a per-pin acknowledge or by a change of that pin's mode. Pin 0 also feeds a wake-up output: while the core reports that it is stopped, a low level on pin 0 raises the wake output so the core can leave the stopped state. Pin 1 has no such path. Which pins can wake is set by a parameter mask.

Top module: `ext_irq_cond`

## Requirements
- R1: During and straight after reset, both requests and the wake output are low, both pins are in level mode and the synchroniser holds the idle (high) pin value.
- R2: A pin change reaches the synchronised level after exactly two rising clock edges. One edge after a pin falls, the level request is still low. After the second edge it is high.
- R3: With mode bit 0 (level), the request equals the inverted synchronised pin, and acknowledge has no effect on it.
- R4: With mode bit 1 (falling edge), a high-to-low change between two successive synchronised samples sets the pending flag, which is the request. The request rises on the third edge after the pin falls and stays high after the pin goes back high. A pin held low, or a rising change, does not set it again.
- R5: In edge mode, acknowledge held at a rising edge clears the pending flag at that edge. If a new falling edge is detected in the same cycle, the flag stays set.
- R6: A write to the mode register (cfg_we high, bit i of cfg_mode is the mode of pin i, 1 = edge) that changes a pin's mode clears that pin's pending flag. A write with the same mode leaves the flag untouched.
- R7: The two pins are independent. Mode, acknowledge and pin activity on one pin do not change the request of the other.
- R8: The wake output is high exactly when stop_mode is high and the synchronised pin 0 is low, in either trigger mode. It follows stop_mode without a clock delay.
- R9: Pin 1 never raises the wake output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_n | input | 2 | Active-low external request pins, asynchronous |
| cfg_we | input | 1 | Write strobe for the mode register |
| cfg_mode | input | 2 | Mode value per pin: 0 level, 1 falling edge |
| ack | input | 2 | Per-pin acknowledge, clears a pending edge request |
| stop_mode | input | 1 | High while the core is stopped |
| irq_req | output | 2 | Active-high interrupt request per pin |
| wake | output | 1 | Wake-up request for the stopped core |

## Verification
Single pins are walked low and high with the sample taken one and two edges later, which separates a correct two-stage synchroniser from one with too few or too many stages. In edge mode the tests use pin pulses, a pin held low, acknowledges with and without a coincident new edge, and mode writes that do and do not change the mode. These tell a latched request from a level copy and show that acknowledge and mode writes take priority correctly. A sweep over all four mode combinations and all four pin patterns, with stop_mode high, compares both requests and the wake output against a bench model. This shows that the pins do not interfere with each other and that only pin 0 can wake the core.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_mode_e;

  // older sample high, newer sample low: a falling transition
  function automatic logic fall_seen(input logic older_n, input logic newer_n);
    return older_n & ~newer_n;
  endfunction

  // priority: mode flush, then new edge, then acknowledge
  function automatic logic next_pending(input logic cur, input logic set,
                                        input logic clr, input logic flush);
    logic nxt;
    if (flush)    nxt = 1'b0;
    else if (set) nxt = 1'b1;
    else if (clr) nxt = 1'b0;
    else          nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic sync_n,
  output logic prev_n
);

  logic meta_q;
  logic stab_q;
  logic hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      stab_q <= 1'b1;
      hist_q <= 1'b1;
    end else begin
      meta_q <= pin_n;
      stab_q <= meta_q;
      hist_q <= stab_q;
    end
  end

  assign sync_n = stab_q;
  assign prev_n = hist_q;

endmodule

// File: rtl/irq_trigger.sv
module irq_trigger
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       mode_flush,
  input  logic       sync_n,
  input  logic       prev_n,
  input  logic       ack,
  output logic       req,
  output logic       pending,
  output logic       fall_evt
);

  logic pend_q;

  assign fall_evt = (mode == TRIG_FALL) && fall_seen(prev_n, sync_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= next_pending(pend_q, fall_evt, ack, mode_flush);
  end

  assign pending = pend_q;
  assign req     = (mode == TRIG_FALL) ? pend_q : ~sync_n;

endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int                    NUM_PINS  = 2,
  parameter logic [NUM_PINS-1:0]   WAKE_MASK = 2'b01
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_pin_n,
  input  logic                cfg_we,
  input  logic [NUM_PINS-1:0] cfg_mode,
  input  logic [NUM_PINS-1:0] ack,
  input  logic                stop_mode,
  output logic [NUM_PINS-1:0] irq_req,
  output logic                wake
);

  logic [NUM_PINS-1:0] mode_q;
  logic [NUM_PINS-1:0] mode_flush;
  logic [NUM_PINS-1:0] sync_n;
  logic [NUM_PINS-1:0] prev_n;
  logic [NUM_PINS-1:0] pending;
  logic [NUM_PINS-1:0] fall_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= '0;
    else if (cfg_we) mode_q <= cfg_mode;
  end

  assign mode_flush = {NUM_PINS{cfg_we}} & (cfg_mode ^ mode_q);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    irq_sync u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_n  (irq_pin_n[i]),
      .sync_n (sync_n[i]),
      .prev_n (prev_n[i])
    );

    irq_trigger u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (trig_mode_e'(mode_q[i])),
      .mode_flush (mode_flush[i]),
      .sync_n     (sync_n[i]),
      .prev_n     (prev_n[i]),
      .ack        (ack[i]),
      .req        (irq_req[i]),
      .pending    (pending[i]),
      .fall_evt   (fall_evt[i])
    );
  end

  assign wake = stop_mode & (|(WAKE_MASK & ~sync_n));

endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int                  NUM_PINS  = 2,
  parameter logic [NUM_PINS-1:0] WAKE_MASK = 2'b01
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] irq_pin_n,
  input logic                cfg_we,
  input logic [NUM_PINS-1:0] cfg_mode,
  input logic [NUM_PINS-1:0] ack,
  input logic                stop_mode,
  input logic [NUM_PINS-1:0] irq_req,
  input logic                wake,
  input logic [NUM_PINS-1:0] mode_q,
  input logic [NUM_PINS-1:0] sync_n,
  input logic [NUM_PINS-1:0] pending,
  input logic [NUM_PINS-1:0] fall_evt
);

  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    // R2: two-stage synchroniser latency
    a_r2_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (sync_n[i] == $past(irq_pin_n[i], 2)));

    // R3: level mode request tracks the synchronised pin
    a_r3_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] == 1'b0) |-> (irq_req[i] == ~sync_n[i]));

    // R4: a detected fall latches the request
    a_r4_fall_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_evt[i] && !(cfg_we && (cfg_mode[i] != mode_q[i]))) |=> irq_req[i]);

    // R4: a latched request holds without acknowledge
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] && irq_req[i] && !ack[i] && !cfg_we) |=> irq_req[i]);

    // R5: acknowledge without a new fall clears
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[i] && ack[i] && !fall_evt[i] && !cfg_we) |=> !irq_req[i]);

    // R6: a mode change flushes the pending flag
    a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && (cfg_mode[i] != mode_q[i])) |=> !pending[i]);
  end

  // R8: wake only while stopped
  a_r8_wake_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> stop_mode);

  // R8, R9: wake only from a pin enabled in the mask that is low
  a_r9_wake_source: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (|(WAKE_MASK & ~sync_n)));

endmodule

bind ext_irq_cond ext_irq_chk #(
  .NUM_PINS  (NUM_PINS),
  .WAKE_MASK (WAKE_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_pin_n (irq_pin_n),
  .cfg_we    (cfg_we),
  .cfg_mode  (cfg_mode),
  .ack       (ack),
  .stop_mode (stop_mode),
  .irq_req   (irq_req),
  .wake      (wake),
  .mode_q    (mode_q),
  .sync_n    (sync_n),
  .pending   (pending),
  .fall_evt  (fall_evt)
);

// File: tb/ext_irq_cond_tb.sv
module ext_irq_cond_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin_n = 2'b11;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [1:0] ack = 2'b00;
  logic       stop = 1'b0;
  logic [1:0] req;
  logic       wake;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ext_irq_cond u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pin_n (pin_n),
    .cfg_we    (cfg_we),
    .cfg_mode  (cfg_mode),
    .ack       (ack),
    .stop_mode (stop),
    .irq_req   (req),
    .wake      (wake)
  );

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_mode(input logic [1:0] m);
    cfg_mode = m;
    cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] cur_mode;
    logic [1:0] exp_pend;
    logic [1:0] prev;
    logic [1:0] exp_req;
    step(3);
    chk("R1 req in reset", {2'b0, req}, 4'h0);
    rst_n = 1'b1;
    step(1);
    chk("R1 req after reset", {2'b0, req}, 4'h0);
    chk("R1 wake after reset", {3'b0, wake}, 4'h0);

    // level mode, synchroniser latency
    pin_n = 2'b10;
    step(1);
    chk("R2 one edge", {2'b0, req}, 4'h0);
    step(1);
    chk("R2 two edges", {2'b0, req}, 4'h1);
    ack = 2'b01;
    step(1);
    ack = 2'b00;
    chk("R3 ack ignored in level", {2'b0, req}, 4'h1);
    pin_n = 2'b11;
    step(2);
    chk("R3 level release", {2'b0, req}, 4'h0);

    // edge mode
    write_mode(2'b11);
    pin_n = 2'b10;
    step(2);
    chk("R4 not yet latched", {2'b0, req}, 4'h0);
    step(1);
    chk("R4 latched", {2'b0, req}, 4'h1);
    pin_n = 2'b11;
    step(4);
    chk("R4 holds after release", {2'b0, req}, 4'h1);
    ack = 2'b01;
    step(1);
    ack = 2'b00;
    chk("R5 ack clears", {2'b0, req}, 4'h0);
    pin_n = 2'b10;
    step(4);
    chk("R4 second fall", {2'b0, req}, 4'h1);
    ack = 2'b01;
    step(1);
    ack = 2'b00;
    step(4);
    chk("R4 steady low no retrigger", {2'b0, req}, 4'h0);

    // acknowledge coincident with a new fall
    pin_n = 2'b11;
    step(3);
    pin_n = 2'b10;
    step(3);
    chk("R4 pending before coincident", {2'b0, req}, 4'h1);
    pin_n = 2'b11;
    step(3);
    pin_n = 2'b10;
    step(2);
    ack = 2'b01;
    step(1);
    ack = 2'b00;
    chk("R5 new fall beats ack", {2'b0, req}, 4'h1);
    ack = 2'b01;
    step(1);
    ack = 2'b00;
    chk("R5 plain ack clears", {2'b0, req}, 4'h0);

    // mode writes
    pin_n = 2'b11;
    step(3);
    pin_n = 2'b10;
    step(3);
    write_mode(2'b11);
    chk("R6 same mode keeps", {2'b0, req}, 4'h1);
    write_mode(2'b10);
    chk("R6 level view while low", {2'b0, req}, 4'h1);
    write_mode(2'b11);
    chk("R6 change flushed pending", {2'b0, req}, 4'h0);
    pin_n = 2'b11;
    step(3);

    // wake path
    stop = 1'b1;
    pin_n = 2'b01;
    step(2);
    chk("R9 pin1 no wake", {3'b0, wake}, 4'h0);
    pin_n = 2'b00;
    step(1);
    chk("R8 wake after one edge", {3'b0, wake}, 4'h0);
    step(1);
    chk("R8 wake raised", {3'b0, wake}, 4'h1);
    stop = 1'b0;
    #1;
    chk("R8 wake drops with stop", {3'b0, wake}, 4'h0);
    pin_n = 2'b11;
    step(3);
    ack = 2'b11;
    step(1);
    ack = 2'b00;

    // sweep over modes and pin patterns
    cur_mode = 2'b11;
    exp_pend = 2'b00;
    prev = 2'b11;
    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        exp_pend = exp_pend & ~(cur_mode ^ 2'(m));
        cur_mode = 2'(m);
        write_mode(cur_mode);
        stop = 1'b1;
        pin_n = 2'(p);
        for (int i = 0; i < 2; i++)
          if (cur_mode[i] && prev[i] && !pin_n[i]) exp_pend[i] = 1'b1;
        step(4);
        for (int i = 0; i < 2; i++)
          exp_req[i] = cur_mode[i] ? exp_pend[i] : ~pin_n[i];
        chk("R7 sweep req", {2'b0, req}, {2'b0, exp_req});
        chk("R8 sweep wake", {3'b0, wake}, {3'b0, ~pin_n[0]});
        ack = 2'b11;
        step(1);
        ack = 2'b00;
        exp_pend = 2'b00;
        for (int i = 0; i < 2; i++)
          exp_req[i] = cur_mode[i] ? 1'b0 : ~pin_n[i];
        chk("R5 sweep after ack", {2'b0, req}, {2'b0, exp_req});
        pin_n = 2'b11;
        stop = 1'b0;
        step(4);
        prev = 2'b11;
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule